// File: doc/BRIEF.md
# Shared-Address Serial Data Port

This block sits between a processor bus and the shift engine of a serial peripheral. It exposes one data register location. A bus write to that location adds data to a transmit queue. A bus read from the same location takes data from a receive queue. The two queues use separate storage and never interact. The processor picks the access unit (one, two or four bytes) with a width control input. Software must set that unit to match the frame data length it has configured for the shift engine.

Both queues count their contents in bytes, so traffic of mixed widths is tracked exactly. A write is all-or-nothing: it enters the transmit queue only if the free space can take the whole unit. Otherwise it is discarded and a sticky overflow-attempt flag is raised. A read that finds fewer bytes than the unit returns zero, removes nothing and raises a sticky underflow flag. Toward the shift engine, the transmit queue gives out one byte at a time through a valid/ready handshake. The receive queue takes in one byte at a time through the same kind of handshake.

Top module: `shared_data_port`

## Requirements
- R1: While reset is asserted and after it is released, both queues are empty: `tx_valid` is 0, `rx_ready` is 1, `bus_rdata` is 0, and both flags are 0.
- R2: `acc_width` selects the access unit. 2'b00 is 1 byte, 2'b01 is 2 bytes, and 2'b10 and 2'b11 are both 4 bytes. An accepted write enqueues that many low bytes of `bus_wdata`, starting with `bus_wdata[7:0]`.
- R3: Each queue holds 32 bytes. A write at offset 0 is accepted only when the transmit free space is at least the unit size. Otherwise no byte of it is stored and the transmit contents are unchanged.
- R4: A discarded write sets `ovf_flag` on the following edge. The flag stays set until an edge on which `ovf_clr` is 1 and no new discard happens. A discard wins over a clear in the same cycle.
- R5: A read at offset 0, when the receive queue holds at least the unit size, dequeues that many bytes. The oldest byte goes to `bus_rdata[7:0]` and the unused upper lanes read as 0. `bus_rdata` updates on the edge that takes the read and holds until the next read.
- R6: A read at offset 0, when the receive queue holds fewer bytes than the unit size, returns 0 and removes nothing. It sets `unf_flag`, which follows the same sticky rule as R4 but uses `unf_clr`.
- R7: A read or write with a nonzero `bus_offs` is ignored. It changes no queue and no flag, and leaves `bus_rdata` unchanged.
- R8: `tx_valid` is 1 whenever the transmit queue is not empty, and `tx_data` is its oldest byte. That byte is removed on an edge with `tx_valid` and `tx_ready` both 1.
- R9: `rx_ready` is 1 whenever the receive queue holds fewer than 32 bytes. `rx_data` is appended on an edge with `rx_valid` and `rx_ready` both 1.
- R10: The write admission check uses the transmit count from before that cycle's engine pop. The read admission check uses the receive count from before that cycle's engine push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_offs | input | 2 | Byte offset within the data register |
| acc_width | input | 2 | Access unit select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ovf_clr | input | 1 | Clears the overflow-attempt flag |
| unf_clr | input | 1 | Clears the underflow flag |
| ovf_flag | output | 1 | Sticky discarded-write flag |
| unf_flag | output | 1 | Sticky empty-read flag |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Shift engine takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Shift engine offers a receive byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Receive byte |

## Verification
On every cycle the assertions check several invariants. Queue occupancy never passes 32 and never goes below zero. A discarded write leaves the transmit count moved only by the engine pop and always raises the overflow flag. A short read returns zero and always raises the underflow flag. An off-offset read leaves the read data stable. Other properties can only be shown by the bench's scenarios against its byte-queue model: the byte order across mixed widths, the lane masking of narrow reads, the admission decision when a pop or push falls in the same cycle as a bus access, and the exact cycle when a flag clears.

// File: rtl/dp_pkg.sv
package dp_pkg;

  localparam int MAX_UNIT = 4;

  typedef enum logic [1:0] {
    ACC_B8   = 2'b00,
    ACC_B16  = 2'b01,
    ACC_B32  = 2'b10,
    ACC_B32X = 2'b11
  } acc_width_e;

  // Bytes moved by one bus access of the given width code.
  function automatic logic [2:0] unit_bytes(input logic [1:0] sel);
    case (acc_width_e'(sel))
      ACC_B8:  return 3'd1;
      ACC_B16: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Lane mask keeping the low nb bytes of a bus word.
  function automatic logic [8*MAX_UNIT-1:0] lane_mask(input logic [2:0] nb);
    logic [8*MAX_UNIT-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_UNIT; i++) begin
      if (i < int'(nb)) m[8*i +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

endmodule

// File: rtl/mbyte_fifo.sv
module mbyte_fifo #(
  parameter int DEPTH = 32,
  parameter int MAXN  = 4,
  parameter int PUSHN = 4,
  parameter int PEEKN = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(MAXN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      push_n,
  input  logic [8*PUSHN-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [8*PEEKN-1:0] peek_data,
  output logic [LW-1:0]      level
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] p, input int k);
    int s;
    s = (int'(p) + k) % DEPTH;
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSHN; i++) begin
      if (i < int'(push_n)) mem[wrap(wr_ptr, i)] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < PEEKN; g++) begin : g_peek
    assign peek_data[8*g +: 8] = mem[wrap(rd_ptr, g)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wrap(wr_ptr, int'(push_n));
      rd_ptr <= wrap(rd_ptr, int'(pop_n));
      level  <= level + LW'(push_n) - LW'(pop_n);
    end
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(push_n) + int'(level) - int'(pop_n) <= DEPTH);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(level));

endmodule

// File: rtl/shared_data_port.sv
module shared_data_port
  import dp_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int BW = 8 * MAX_UNIT,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(MAX_UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_offs,
  input  logic [1:0]    acc_width,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          ovf_clr,
  input  logic          unf_clr,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data
);

  // Named events for the assertions.
  logic [2:0]    unit_nb;
  logic          wr_hit, rd_hit;
  logic          wr_accept, wr_drop;
  logic          rd_accept, rd_under;
  logic          tx_pop, rx_push;
  logic [LW-1:0] tx_level, rx_level, tx_free;
  logic [BW-1:0] rx_peek;

  assign unit_nb   = unit_bytes(acc_width);
  assign wr_hit    = bus_wr && (bus_offs == 2'b00);
  assign rd_hit    = bus_rd && (bus_offs == 2'b00);
  assign tx_free   = LW'(DEPTH) - tx_level;
  assign wr_accept = wr_hit && (LW'(unit_nb) <= tx_free);
  assign wr_drop   = wr_hit && !wr_accept;
  assign rd_accept = rd_hit && (LW'(unit_nb) <= rx_level);
  assign rd_under  = rd_hit && !rd_accept;
  assign tx_valid  = (tx_level != '0);
  assign tx_pop    = tx_valid && tx_ready;
  assign rx_ready  = (rx_level != LW'(DEPTH));
  assign rx_push   = rx_valid && rx_ready;

  mbyte_fifo #(.DEPTH(DEPTH), .MAXN(MAX_UNIT), .PUSHN(MAX_UNIT), .PEEKN(1)) tx_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (wr_accept ? NW'(unit_nb) : NW'(0)),
    .push_data (bus_wdata),
    .pop_n     (NW'(tx_pop)),
    .peek_data (tx_data),
    .level     (tx_level)
  );

  mbyte_fifo #(.DEPTH(DEPTH), .MAXN(MAX_UNIT), .PUSHN(1), .PEEKN(MAX_UNIT)) rx_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (NW'(rx_push)),
    .push_data (rx_data),
    .pop_n     (rd_accept ? NW'(unit_nb) : NW'(0)),
    .peek_data (rx_peek),
    .level     (rx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_accept ? (rx_peek & lane_mask(unit_nb)) : '0;
  end

  sticky_flag ovf_i (.clk(clk), .rst_n(rst_n), .set(wr_drop),  .clr(ovf_clr), .q(ovf_flag));
  sticky_flag unf_i (.clk(clk), .rst_n(rst_n), .set(rd_under), .clr(unf_clr), .q(unf_flag));

  assert_drop_keeps_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> tx_level == $past(tx_level) - LW'($past(tx_pop)));

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf_flag);

  assert_under_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_under |=> (bus_rdata == '0) && unf_flag
                 && (rx_level == $past(rx_level) + LW'($past(rx_push))));

  assert_offset_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_offs != 2'b00) |=> $stable(bus_rdata));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

  assert_rx_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rd_accept) |=> !rx_ready);

endmodule

// File: tb/shared_data_port_tb.sv
`timescale 1ns/1ps
module shared_data_port_tb_top;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_offs = 0, acc_width = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ovf_clr = 0, unf_clr = 0;
  logic        ovf_flag, unf_flag;
  logic        tx_valid, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        rx_valid = 0, rx_ready;
  logic [7:0]  rx_data = 0;

  always #10 clk = ~clk;

  shared_data_port #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_offs(bus_offs), .acc_width(acc_width), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_clr(ovf_clr), .unf_clr(unf_clr),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // Behavioural reference: byte queues and flags.
  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  logic        m_ovf = 0, m_unf = 0;
  logic [31:0] m_rdata = 0;
  int          n_chk = 0, n_fail = 0;
  string       phase = "R1";
  bit          done = 0;

  function automatic int nbytes(input logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  task automatic model_step();
    int  txn = m_tx.size();
    int  rxn = m_rx.size();
    int  nb  = nbytes(acc_width);
    bit  pop = (txn > 0) && tx_ready;
    bit  wr0 = bus_wr && (bus_offs == 0);
    bit  wok = wr0 && (nb <= DEPTH - txn);
    bit  rd0 = bus_rd && (bus_offs == 0);
    bit  rok = rd0 && (nb <= rxn);
    bit  psh = rx_valid && (rxn < DEPTH);
    if (pop) void'(m_tx.pop_front());
    if (wok) for (int k = 0; k < nb; k++) m_tx.push_back(bus_wdata[8*k +: 8]);
    if (rd0) begin
      m_rdata = 0;
      if (rok) for (int k = 0; k < nb; k++) m_rdata[8*k +: 8] = m_rx.pop_front();
    end
    if (psh) m_rx.push_back(rx_data);
    m_ovf = (wr0 && !wok) ? 1'b1 : ovf_clr ? 1'b0 : m_ovf;
    m_unf = (rd0 && !rok) ? 1'b1 : unf_clr ? 1'b0 : m_unf;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/%s %s actual=%h expected=%h at %0t", phase, req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ev = m_tx.size() > 0;
    chk("R8", "tx_valid", 32'(tx_valid), 32'(ev));
    if (ev) chk("R8", "tx_data", 32'(tx_data), 32'(m_tx[0]));
    chk("R9", "rx_ready", 32'(rx_ready), 32'(m_rx.size() < DEPTH));
    chk("R5", "bus_rdata", bus_rdata, m_rdata);
    chk("R4", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
    chk("R6", "unf_flag", 32'(unf_flag), 32'(m_unf));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    compare();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_offs = 0; ovf_clr = 0; unf_clr = 0;
    rx_valid = 0; tx_ready = 0;
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d, input logic [1:0] o = 0);
    bus_wr = 1; acc_width = w; bus_wdata = d; bus_offs = o;
    tick(); idle();
  endtask

  task automatic rd(input logic [1:0] w, input logic [1:0] o = 0);
    bus_rd = 1; acc_width = w; bus_offs = o;
    tick(); idle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    // R1: reset state, during and after reset
    @(negedge clk); @(negedge clk);
    phase = "R1"; compare();
    rst_n = 1;
    tick(); tick();

    // R2: mixed widths, byte order, then drain
    phase = "R2";
    wr(2'b00, 32'hFFFF_FF11);
    wr(2'b01, 32'hEEEE_3322);
    wr(2'b10, 32'h7766_5544);
    wr(2'b11, 32'hBBAA_9988);
    tx_ready = 1;
    repeat (12) tick();
    idle();

    // R3 / R4: fill transmit queue, discarded writes, flag clear and priority
    phase = "R3";
    for (int i = 0; i < 8; i++) wr(2'b10, 32'h0101_0101 * (i + 1));
    wr(2'b00, 32'h0000_00EE);
    phase = "R4";
    tick();
    bus_wr = 1; acc_width = 2'b00; ovf_clr = 1; tick(); idle();
    ovf_clr = 1; tick(); idle();
    tx_ready = 1; tick(); idle();
    phase = "R3";
    wr(2'b01, 32'h0000_C0DE);
    wr(2'b00, 32'h0000_00AB);
    tx_ready = 1; repeat (34) tick(); idle();

    // R9: fill receive queue past capacity
    phase = "R9";
    rx_valid = 1;
    for (int i = 0; i < 35; i++) begin rx_data = 8'(i + 8'h40); tick(); end
    idle();

    // R5: reads of each width
    phase = "R5";
    rd(2'b00); rd(2'b01); rd(2'b10); rd(2'b11); tick();

    // R7: off-offset accesses ignored
    phase = "R7";
    rd(2'b00, 2'b01); rd(2'b10, 2'b10);
    wr(2'b00, 32'h5A, 2'b11); wr(2'b10, 32'h1234_5678, 2'b01);
    tick();

    // R6: drain to 3 bytes, then a word read
    phase = "R6";
    for (int i = 0; i < 4; i++) rd(2'b10);
    rd(2'b00); rd(2'b00);
    rd(2'b10);
    rd(2'b01); rd(2'b10);
    unf_clr = 1; tick(); idle();
    rd(2'b00); rd(2'b00);

    // R10: admission uses occupancy before same-cycle pop/push
    phase = "R10";
    for (int i = 0; i < 8; i++) wr(2'b10, 32'hA5A5_0000 + i);
    bus_wr = 1; acc_width = 2'b00; bus_wdata = 32'h77; tx_ready = 1; tick(); idle();
    rx_valid = 1; rx_data = 8'h99; bus_rd = 1; acc_width = 2'b00; tick(); idle();
    rd(2'b00);
    tx_ready = 1; repeat (34) tick(); idle();
    ovf_clr = 1; unf_clr = 1; tick(); idle();

    // R10: random mixed traffic
    for (int c = 0; c < 1500; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_wr    = lfsr[0] & lfsr[1];
      bus_rd    = lfsr[2] & lfsr[3] & ~bus_wr;
      acc_width = lfsr[5:4];
      bus_offs  = (lfsr[9:6] == 4'hF) ? 2'b01 : 2'b00;
      bus_wdata = {lfsr, lfsr ^ 16'h3C5A};
      tx_ready  = lfsr[10];
      rx_valid  = lfsr[11] | lfsr[12];
      rx_data   = lfsr[15:8];
      ovf_clr   = (lfsr[15:13] == 3'b111);
      unf_clr   = (lfsr[14:12] == 3'b000);
      tick();
    end
    idle(); tick();

    done = 1;
    summary();
    $finish;
  end

endmodule